// File: doc/BRIEF.md
# GPIO Controller with Per-Pin Interrupt Detection

This block is a register-mapped general-purpose I/O controller for a configurable number of pins, up to 32. Software picks each pin's direction, sets the level driven on output pins and reads back the pin states. Every pin feeds its own event detector, configured by software in one of three trigger modes. The modes are LEVEL (active high or active low), EDGE (rising only or falling only) and ANY (every transition).

Detected events are latched into a status register. They stay there until software writes a one to the matching bit of a clear register. A pending register is the status masked by an enable register. A single interrupt line, registered one cycle after the pending bits, is raised while any pending bit is set.

The register bus is 32 bits wide with word addresses. Reads are combinational and have no side effects. A write takes effect at the clock edge on which `bus_wr` is high. Pin inputs are resynchronised through two flops before any use.

Top module: `gpio_irq_ctrl`

## Requirements
- R1: After reset, every pin is an input (direction reads all ones over the implemented pins), the value register reads 0, enable, status, edge-select and any-edge registers read 0, polarity reads all ones, `pin_oe` is 0 and `irq` is low.
- R2: The direction register (word 0) makes pin n an input when bit n is 1 and an output when bit n is 0, and `pin_oe[n]` is the inverse of that bit. Writing the value register (word 1) sets `pin_out`. Reading word 1 returns the synchronised pin input for input pins and the driven level for output pins.
- R3: In LEVEL mode (edge-select bit n = 0 at word 6, any-edge bit n = 0 at word 9), polarity bit n = 1 at word 7 latches an event while the pin is high, and polarity bit n = 0 latches an event while it is low. A clear issued while the active level persists does not leave the status bit at 0.
- R4: In EDGE mode (edge-select bit = 1, any-edge bit = 0), polarity 1 latches rising transitions only and polarity 0 latches falling transitions only.
- R5: In ANY mode (any-edge bit = 1), both rising and falling transitions latch an event, whatever the edge-select and polarity bits hold.
- R6: Writing a 1 to bit n of the clear register (word 5) clears status bit n (read at word 3). Writing 0 leaves it unchanged.
- R7: When a new event and a clear of the same bit coincide on one clock edge, the status bit stays set.
- R8: The pending register (word 4) reads status AND enable (enable at word 2). The status register reports events whether or not they are enabled.
- R9: `irq` is the OR of the pending bits, delayed by one register stage. It is low one cycle after the enable register becomes all zeros. The enable register changes only when it is written.
- R10: The version register (word 8) reads 3: bit 0 marks the base revision and bit 1 marks that ANY mode exists.
- R11: Writes to the status, pending and version registers have no effect. Register bits above the pin count read 0. A pin edge is visible in status three clock edges after the pin changes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 4 | Register word address |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from `bus_addr` |
| pin_in | input | NPINS | Raw pin levels from the pads |
| pin_out | output | NPINS | Levels to drive on output pins |
| pin_oe | output | NPINS | Output enable per pin, 1 = drive |
| irq | output | 1 | Interrupt request, high while any pending bit is set |

## Verification
Each trigger mode is exercised on its own pin with both a rising and a falling transition. A missed edge therefore shows up as a status bit that stays clear, and a wrongly accepted edge as a bit that sets. Level mode is tried in both polarities, with a clear issued while the level is still active, which separates a level detector from an edge detector. A clear is timed onto the exact edge on which a new event lands, which separates event-wins priority from clear-wins priority. The interrupt line is sampled on the cycle before and the cycle after its expected rise, which pins down the register stage.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

    localparam int ADDR_W = 4;
    localparam int DATA_W = 32;

    typedef enum logic [ADDR_W-1:0] {
        A_DIR   = 4'd0,
        A_VAL   = 4'd1,
        A_IEN   = 4'd2,
        A_IST   = 4'd3,
        A_IPEND = 4'd4,
        A_ICLR  = 4'd5,
        A_EDGE  = 4'd6,
        A_POL   = 4'd7,
        A_VER   = 4'd8,
        A_BOTH  = 4'd9
    } reg_addr_e;

    typedef enum logic [1:0] {
        TRIG_LEVEL,
        TRIG_EDGE,
        TRIG_ANY
    } trig_mode_e;

    localparam logic [DATA_W-1:0] VER_BASE    = 32'h1;
    localparam logic [DATA_W-1:0] VER_ANY_BIT = 32'h2;

endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= '0;
            q      <= '0;
        end else begin
            meta_q <= d;
            q      <= meta_q;
        end
    end
endmodule

// File: rtl/gpio_detect.sv
module gpio_detect
    import gpio_irq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic lvl,
    input  logic sel_edge,
    input  logic sel_pol,
    input  logic sel_any,
    input  logic clr,
    output logic stat
);
    logic       prev_q;
    logic       rise;
    logic       fall;
    logic       evt;
    trig_mode_e mode;

    assign rise = lvl & ~prev_q;
    assign fall = ~lvl & prev_q;

    always_comb begin
        if (sel_any)       mode = TRIG_ANY;
        else if (sel_edge) mode = TRIG_EDGE;
        else               mode = TRIG_LEVEL;
    end

    always_comb begin
        unique case (mode)
            TRIG_LEVEL: evt = sel_pol ? lvl : ~lvl;
            TRIG_EDGE:  evt = sel_pol ? rise : fall;
            TRIG_ANY:   evt = rise | fall;
            default:    evt = 1'b0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q <= 1'b0;
            stat   <= 1'b0;
        end else begin
            prev_q <= lvl;
            stat   <= evt | (stat & ~clr);
        end
    end

    p_event_sets_r7: assert property (@(posedge clk) disable iff (!rst_n)
        evt |=> stat);
    p_clear_works_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !evt) |=> !stat);
    p_status_holds_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (stat && !clr) |=> stat);
endmodule

// File: rtl/gpio_irq_ctrl.sv
module gpio_irq_ctrl
    import gpio_irq_pkg::*;
#(
    parameter int NPINS        = 24,
    parameter bit HAS_ANY_EDGE = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [NPINS-1:0]  pin_in,
    output logic [NPINS-1:0]  pin_out,
    output logic [NPINS-1:0]  pin_oe,
    output logic              irq
);
    localparam logic [DATA_W-1:0] VERSION =
        HAS_ANY_EDGE ? (VER_BASE | VER_ANY_BIT) : VER_BASE;

    logic [NPINS-1:0] dir_q, val_q, ien_q, edge_q, pol_q, both_q;
    logic [NPINS-1:0] pin_s, stat, pend, clr_mask, wbits;
    logic             unused_wdata;

    assign wbits        = bus_wdata[NPINS-1:0];
    assign unused_wdata = ^bus_wdata;

    gpio_sync #(.W(NPINS)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .d    (pin_in),
        .q    (pin_s)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dir_q  <= '1;
            val_q  <= '0;
            ien_q  <= '0;
            edge_q <= '0;
            pol_q  <= '1;
        end else if (bus_wr) begin
            unique case (bus_addr)
                A_DIR:   dir_q  <= wbits;
                A_VAL:   val_q  <= wbits;
                A_IEN:   ien_q  <= wbits;
                A_EDGE:  edge_q <= wbits;
                A_POL:   pol_q  <= wbits;
                default: ;
            endcase
        end
    end

    generate
        if (HAS_ANY_EDGE) begin : g_any
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)                         both_q <= '0;
                else if (bus_wr && bus_addr == A_BOTH) both_q <= wbits;
            end
        end else begin : g_no_any
            assign both_q = '0;
        end
    endgenerate

    assign clr_mask = (bus_wr && bus_addr == A_ICLR) ? wbits : '0;

    generate
        for (genvar i = 0; i < NPINS; i++) begin : g_pin
            gpio_detect u_det (
                .clk     (clk),
                .rst_n   (rst_n),
                .lvl     (pin_s[i]),
                .sel_edge(edge_q[i]),
                .sel_pol (pol_q[i]),
                .sel_any (both_q[i]),
                .clr     (clr_mask[i]),
                .stat    (stat[i])
            );
        end
    endgenerate

    assign pend    = stat & ien_q;
    assign pin_out = val_q;
    assign pin_oe  = ~dir_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) irq <= 1'b0;
        else        irq <= |pend;
    end

    always_comb begin
        unique case (bus_addr)
            A_DIR:   bus_rdata = DATA_W'(dir_q);
            A_VAL:   bus_rdata = DATA_W'((val_q & ~dir_q) | (pin_s & dir_q));
            A_IEN:   bus_rdata = DATA_W'(ien_q);
            A_IST:   bus_rdata = DATA_W'(stat);
            A_IPEND: bus_rdata = DATA_W'(pend);
            A_EDGE:  bus_rdata = DATA_W'(edge_q);
            A_POL:   bus_rdata = DATA_W'(pol_q);
            A_VER:   bus_rdata = VERSION;
            A_BOTH:  bus_rdata = DATA_W'(both_q);
            default: bus_rdata = '0;
        endcase
    end

    p_ien_stable_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_wr && bus_addr == A_IEN) |=> $stable(ien_q));
    p_irq_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (ien_q == '0) |=> !irq);
    p_oe_dir_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == A_DIR) |=> (pin_oe == ~$past(wbits)));
    p_clear_only_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr != A_ICLR) |=> ((stat & $past(stat)) == $past(stat)));
endmodule

// File: tb/sim_gpio_irq_ctrl.sv
`timescale 1ns/1ps
module sim_gpio_irq_ctrl;
    localparam int NP = 24;
    localparam logic [31:0] PMASK = 32'h00FF_FFFF;
    localparam int K_REG = 0, K_IRQ = 1, K_OUT = 2, K_OE = 3;

    typedef struct {
        int          kind;
        logic [3:0]  addr;
        logic [31:0] exp;
        string       req;
    } item_t;

    logic          clk = 1'b0, rst_n = 1'b0, bus_wr = 1'b0;
    logic [3:0]    wr_addr = '0, rd_addr = '0, bus_addr;
    logic [31:0]   bus_wdata = '0, bus_rdata;
    logic [NP-1:0] pin_in = '0, pin_out, pin_oe;
    logic          irq;
    item_t         q[$];
    int            n_chk = 0, n_fail = 0;
    bit            done = 1'b0;

    assign bus_addr = bus_wr ? wr_addr : rd_addr;
    always #10 clk = ~clk;

    gpio_irq_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
        .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq)
    );

    // monitor: pops expected items and compares against the design
    always begin
        @(negedge clk);
        if (q.size() > 0) begin
            item_t it;
            logic [31:0] act;
            it = q[0];
            if (it.kind == K_REG) rd_addr = it.addr;
            #1;
            case (it.kind)
                K_REG:   act = bus_rdata;
                K_IRQ:   act = {31'd0, irq};
                K_OUT:   act = 32'(pin_out);
                default: act = 32'(pin_oe);
            endcase
            n_chk++;
            if (act !== it.exp) begin
                n_fail++;
                $display("FAIL %s kind=%0d addr=%0d actual=%h expected=%h",
                         it.req, it.kind, it.addr, act, it.exp);
            end
            void'(q.pop_front());
        end
    end

    task automatic chk(int kind, logic [3:0] a, logic [31:0] e, string r);
        item_t it;
        @(posedge clk);
        it.kind = kind; it.addr = a; it.exp = e; it.req = r;
        q.push_back(it);
        wait (q.size() == 0);
    endtask

    task automatic wr(logic [3:0] a, logic [31:0] d);
        @(negedge clk);
        wr_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic setpin(int i, logic v);
        @(negedge clk);
        pin_in[i] = v;
        repeat (4) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++; n_chk++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        chk(K_REG, 4'd0, PMASK, "R1 dir");
        chk(K_REG, 4'd1, 32'h0, "R1 value");
        chk(K_REG, 4'd2, 32'h0, "R1 enable");
        chk(K_REG, 4'd3, 32'h0, "R1 status");
        chk(K_REG, 4'd7, PMASK, "R1 polarity");
        chk(K_REG, 4'd6, 32'h0, "R1 edge");
        chk(K_REG, 4'd9, 32'h0, "R1 anyedge");
        chk(K_IRQ, 4'd0, 32'h0, "R1 irq");
        chk(K_OE,  4'd0, 32'h0, "R1 oe");
        // R10 version
        chk(K_REG, 4'd8, 32'h3, "R10 version");
        // R2 direction and value
        wr(4'd0, 32'h00FF_FFF0);
        wr(4'd1, 32'h0000_000A);
        chk(K_OUT, 4'd0, 32'h0000_000A, "R2 pin_out");
        chk(K_OE,  4'd0, 32'h0000_000F, "R2 pin_oe");
        setpin(8, 1'b1);
        chk(K_REG, 4'd1, 32'h0000_010A, "R2 value readback");
        // R3 level high, R8 status without enable
        chk(K_REG, 4'd3, 32'h0000_0100, "R3 level high sets");
        chk(K_REG, 4'd4, 32'h0, "R8 pending masked");
        chk(K_IRQ, 4'd0, 32'h0, "R9 irq masked");
        wr(4'd5, 32'h0000_0100);
        chk(K_REG, 4'd3, 32'h0000_0100, "R3 level persists over clear");
        setpin(8, 1'b0);
        wr(4'd5, 32'h0);
        chk(K_REG, 4'd3, 32'h0000_0100, "R6 zero write no effect");
        wr(4'd5, 32'h0000_0100);
        chk(K_REG, 4'd3, 32'h0, "R6 clear");
        // R3 level low
        wr(4'd7, 32'h00FF_FDFF);
        repeat (4) @(negedge clk);
        chk(K_REG, 4'd3, 32'h0000_0200, "R3 level low sets");
        setpin(9, 1'b1);
        wr(4'd5, 32'h0000_0200);
        chk(K_REG, 4'd3, 32'h0, "R3 level low released");
        // R4 rising only on pin 10
        wr(4'd6, 32'h0000_0400);
        setpin(10, 1'b1);
        chk(K_REG, 4'd3, 32'h0000_0400, "R4 rising sets");
        wr(4'd5, 32'h0000_0400);
        setpin(10, 1'b0);
        chk(K_REG, 4'd3, 32'h0, "R4 falling ignored in rising mode");
        // R4 falling only on pin 11
        wr(4'd6, 32'h0000_0C00);
        wr(4'd7, 32'h00FF_F5FF);
        setpin(11, 1'b1);
        chk(K_REG, 4'd3, 32'h0, "R4 rising ignored in falling mode");
        setpin(11, 1'b0);
        chk(K_REG, 4'd3, 32'h0000_0800, "R4 falling sets");
        wr(4'd5, 32'h0000_0800);
        // R5 any-edge on pin 12
        wr(4'd9, 32'h0000_1000);
        setpin(12, 1'b1);
        chk(K_REG, 4'd3, 32'h0000_1000, "R5 rise sets");
        wr(4'd5, 32'h0000_1000);
        setpin(12, 1'b0);
        chk(K_REG, 4'd3, 32'h0000_1000, "R5 fall sets");
        wr(4'd5, 32'h0000_1000);
        // R9 / R11 latency: pin change at N0, status at N3, irq at N4
        wr(4'd2, 32'h0000_1000);
        @(negedge clk);
        pin_in[12] = 1'b1;
        repeat (2) @(negedge clk);
        chk(K_IRQ, 4'd0, 32'h0, "R9 irq one stage late");
        chk(K_IRQ, 4'd0, 32'h1, "R9 irq raised");
        chk(K_REG, 4'd3, 32'h0000_1000, "R11 status latency");
        chk(K_REG, 4'd4, 32'h0000_1000, "R8 pending");
        wr(4'd2, 32'h0);
        chk(K_IRQ, 4'd0, 32'h0, "R9 irq low when disabled");
        chk(K_REG, 4'd4, 32'h0, "R8 pending after disable");
        // R7 event and clear on the same edge
        @(negedge clk);
        pin_in[12] = 1'b0;
        @(negedge clk);
        @(negedge clk);
        wr_addr = 4'd5; bus_wdata = 32'h0000_1000; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
        chk(K_REG, 4'd3, 32'h0000_1000, "R7 event wins over clear");
        wr(4'd5, 32'h0000_1000);
        chk(K_REG, 4'd3, 32'h0, "R7 later clear");
        // R11 read-only registers and unimplemented bits
        wr(4'd2, 32'hFFFF_FFFF);
        chk(K_REG, 4'd2, PMASK, "R11 upper bits read zero");
        wr(4'd2, 32'h0);
        wr(4'd3, 32'hFFFF_FFFF);
        chk(K_REG, 4'd3, 32'h0, "R11 status not writable");
        wr(4'd8, 32'hFFFF_FFFF);
        chk(K_REG, 4'd8, 32'h3, "R11 version not writable");
        wr(4'd4, 32'hFFFF_FFFF);
        chk(K_REG, 4'd4, 32'h0, "R11 pending not writable");
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule